// File: doc/BRIEF.md
# Page-Mode DRAM Core and Controller

This block is a cycle-accurate model of a small dynamic memory and the controller that drives it. The storage is a grid of multi-bit supercells. The core owns one row buffer. A row strobe copies a whole row of the grid into that buffer. A column strobe then picks one supercell out of the buffer, either to read it or to overwrite it. A precharge command copies the buffer back into the row it came from. Row and column numbers share one narrow command address bus, so each number travels in its own strobe phase.

The controller presents a word-wide request/acknowledge port to the rest of the chip. It remembers which row is open in the buffer. An access to the open row costs only a column strobe. An access to any other row first writes the buffer back, then activates the new row. A free-running timer requests a refresh burst at a fixed cycle interval. A refresh burst closes the open row, then activates each row in turn and writes it back. The refresh burst wins over a waiting request, but an access that has already started always finishes first. The strobe bus leaves the block as outputs, so the command stream can be observed.

Top module: `dram_page_ctrl`

## Requirements
- R1: A request is raised with `req_i` and held until `ack_o`. `ack_o` is high for exactly one cycle per accepted request and never high without a pending request. After `ack_o` the controller spends one cycle before it accepts the next request.
- R2: The request address is `{row, col}`, with the row in the upper `log2(ROWS)` bits. `bus_addr_o` carries the row number in any cycle where `ras_o` is high, and the column number in any cycle where `cas_o` is high.
- R3: An access issues a row strobe only when no row is open or when its row differs from the open row. Each access issues exactly one column strobe.
- R4: A read returns the value most recently written to that address. This holds across row switches and refresh bursts. A column strobe never occurs while no row is open.
- R5: When an access issues a row strobe, its column strobe follows exactly `T_RCD` cycles later.
- R6: `ack_o` rises exactly `T_CL` cycles after the column strobe. On a read, `rdata_o` holds the addressed word while `ack_o` is high.
- R7: While no request arrives, a refresh burst starts every `REFRESH_CYCLES` cycles. Each burst strobes rows 0 to `ROWS-1` in ascending order.
- R8: A due refresh is taken before a waiting request, and an access in progress completes first. A due refresh stays pending until it is taken. After a refresh no row is open, so the next access issues a row strobe even if it targets the previously open row.
- R9: After reset `ack_o`, `ras_o`, `cas_o` and `pre_o` are low, `rdata_o` is zero, and every supercell reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | log2(ROWS)+log2(COLS) | Word address `{row, col}` |
| wdata_i | input | WORD_W | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | WORD_W | Read data, valid with `ack_o` |
| ras_o | output | 1 | Row strobe on the internal command bus |
| cas_o | output | 1 | Column strobe on the internal command bus |
| pre_o | output | 1 | Precharge (buffer write-back) command |
| bus_addr_o | output | max(log2 ROWS, log2 COLS) | Multiplexed row/column number |

## Verification
The bench drives the whole 4x4 grid through several address orders, and each order stresses a different part of the design:
- A row-major sweep mostly reuses the open row, so it separates correct page reuse from a design that strobes the row on every access.
- A column-major sweep changes row on every access, so it exposes a missing or misdirected write-back.
- A stride-5 write pass followed by a reverse read pass mixes both cases and catches data that lands in the wrong supercell.

Long idle stretches show the refresh spacing and the row order within a burst. A read of the previously open row after a refresh shows whether the controller forgets that row.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_ACT,
      ST_RCD,
      ST_COL,
      ST_DATA,
      ST_RPRE,
      ST_RACT,
      ST_RWB
   } dpm_state_e;

   function automatic int dpm_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dpm_core.sv
module dpm_core #(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   parameter int WORD_W = 8,
   parameter int MUX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_i,
   input  logic              cas_i,
   input  logic              pre_i,
   input  logic              we_i,
   input  logic [MUX_W-1:0]  addr_i,
   input  logic [WORD_W-1:0] din_i,
   output logic [WORD_W-1:0] dout_o
);
   localparam int ROW_W = $clog2(ROWS);
   localparam int COL_W = $clog2(COLS);

   typedef logic [COLS-1:0][WORD_W-1:0] row_t;

   row_t             cells [ROWS];
   row_t             rowbuf_q;
   logic [ROW_W-1:0] latched_row_q;
   logic             loaded_q;
   logic [ROWS-1:0]  wb_hit;
   logic [COLS-1:0]  col_hit;

   // one storage row per generate iteration, written back on precharge
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign wb_hit[r] = pre_i && (latched_row_q == ROW_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         cells[r] <= '0;
         else if (wb_hit[r]) cells[r] <= rowbuf_q;
      end
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      assign col_hit[c] = (addr_i[COL_W-1:0] == COL_W'(c));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rowbuf_q      <= '0;
         latched_row_q <= '0;
         loaded_q      <= 1'b0;
         dout_o        <= '0;
      end else if (ras_i) begin
         rowbuf_q      <= cells[addr_i[ROW_W-1:0]];
         latched_row_q <= addr_i[ROW_W-1:0];
         loaded_q      <= 1'b1;
      end else if (cas_i) begin
         for (int c = 0; c < COLS; c++) begin
            if (col_hit[c] && we_i) rowbuf_q[c] <= din_i;
         end
         if (!we_i) dout_o <= rowbuf_q[addr_i[COL_W-1:0]];
      end
   end

   AST_PRE_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      pre_i |-> loaded_q);                                    // R4
   AST_CAS_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      cas_i |-> loaded_q);                                    // R4
   AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ras_i, cas_i, pre_i}) <= 1);               // R3

endmodule

// File: rtl/dpm_refresh.sv
module dpm_refresh #(
   parameter int INTERVAL = 640
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic due_o
);
   localparam int CNT_W = $clog2(INTERVAL);

   logic [CNT_W-1:0] tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         due_o  <= 1'b0;
      end else begin
         if (tick_q == CNT_W'(INTERVAL - 1)) tick_q <= '0;
         else                                tick_q <= tick_q + 1'b1;
         if (tick_q == CNT_W'(INTERVAL - 1)) due_o <= 1'b1;
         else if (start_i)                   due_o <= 1'b0;
      end
   end

   AST_DUE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (due_o && !start_i) |=> due_o);                         // R8
   AST_START_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> due_o);                                     // R8

endmodule

// File: rtl/dpm_seq.sv
module dpm_seq
   import dpm_pkg::*;
#(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int T_RCD = 2,
   parameter int T_CL  = 2,
   parameter int MUX_W = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 req_i,
   input  logic                                 we_i,
   input  logic [$clog2(ROWS)+$clog2(COLS)-1:0] addr_i,
   input  logic                                 ref_due_i,
   output logic                                 ref_start_o,
   output logic                                 ras_o,
   output logic                                 cas_o,
   output logic                                 pre_o,
   output logic                                 cwe_o,
   output logic [MUX_W-1:0]                     mux_o,
   output logic                                 ack_o
);
   localparam int ROW_W = $clog2(ROWS);
   localparam int COL_W = $clog2(COLS);
   localparam int CNT_W = $clog2(dpm_max(T_RCD, T_CL) + 1) + 1;

   if (T_RCD < 1 || T_CL < 1 || T_RCD > 64 || T_CL > 64) begin : g_bad_timing
      $error("dpm_seq: T_RCD and T_CL must lie in 1..64");
   end

   dpm_state_e       state_q;
   logic [ROW_W-1:0] row_q, open_row_q, ridx_q;
   logic [COL_W-1:0] col_q;
   logic             we_q, open_q;
   logic [CNT_W-1:0] cnt_q;
   logic             row_hit;

   assign row_hit = open_q && (addr_i[ROW_W+COL_W-1:COL_W] == open_row_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         row_q      <= '0;
         col_q      <= '0;
         we_q       <= 1'b0;
         open_row_q <= '0;
         open_q     <= 1'b0;
         ridx_q     <= '0;
         cnt_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (ref_due_i) begin
                  state_q <= ST_RPRE;
               end else if (req_i) begin
                  row_q <= addr_i[ROW_W+COL_W-1:COL_W];
                  col_q <= addr_i[COL_W-1:0];
                  we_q  <= we_i;
                  if (row_hit)     state_q <= ST_COL;
                  else if (open_q) state_q <= ST_PRE;
                  else             state_q <= ST_ACT;
               end
            end
            ST_PRE: state_q <= ST_ACT;
            ST_ACT: begin
               open_row_q <= row_q;
               open_q     <= 1'b1;
               if (T_RCD > 1) begin
                  cnt_q   <= CNT_W'(T_RCD - 2);
                  state_q <= ST_RCD;
               end else begin
                  state_q <= ST_COL;
               end
            end
            ST_RCD: begin
               if (cnt_q == '0) state_q <= ST_COL;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            ST_COL: begin
               cnt_q   <= CNT_W'(T_CL - 1);
               state_q <= ST_DATA;
            end
            ST_DATA: begin
               if (cnt_q == '0) state_q <= ST_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            ST_RPRE: begin
               open_q  <= 1'b0;
               ridx_q  <= '0;
               state_q <= ST_RACT;
            end
            ST_RACT: state_q <= ST_RWB;
            ST_RWB: begin
               if (ridx_q == ROW_W'(ROWS - 1)) begin
                  state_q <= ST_IDLE;
               end else begin
                  ridx_q  <= ridx_q + 1'b1;
                  state_q <= ST_RACT;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ras_o       = (state_q == ST_ACT) || (state_q == ST_RACT);
      cas_o       = (state_q == ST_COL);
      pre_o       = (state_q == ST_PRE) || (state_q == ST_RWB) ||
                    ((state_q == ST_RPRE) && open_q);
      cwe_o       = cas_o && we_q;
      ack_o       = (state_q == ST_DATA) && (cnt_q == '0);
      ref_start_o = (state_q == ST_IDLE) && ref_due_i;
      unique case (state_q)
         ST_ACT:  mux_o = MUX_W'(row_q);
         ST_RACT: mux_o = MUX_W'(ridx_q);
         ST_COL:  mux_o = MUX_W'(col_q);
         default: mux_o = '0;
      endcase
   end

   // gap counters for the timing checks
   logic [7:0] since_ras_q, since_cas_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_ras_q <= '0;
         since_cas_q <= '0;
      end else begin
         if (ras_o)                 since_ras_q <= 8'd1;
         else if (since_ras_q != '1) since_ras_q <= since_ras_q + 1'b1;
         if (cas_o)                 since_cas_q <= 8'd1;
         else if (since_cas_q != '1) since_cas_q <= since_cas_q + 1'b1;
      end
   end

   AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      cas_o |-> (since_ras_q >= 8'(T_RCD)));                  // R5
   AST_CL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (since_cas_q == 8'(T_CL)));                   // R6
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);                                      // R1
   AST_CAS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      cas_o |-> open_q);                                      // R4
   AST_REF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      ref_start_o |=> ##1 !open_q);                           // R8

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
   parameter int ROWS           = 4,
   parameter int COLS           = 4,
   parameter int WORD_W         = 8,
   parameter int T_RCD          = 2,
   parameter int T_CL           = 2,
   parameter int REFRESH_CYCLES = 640
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 req_i,
   input  logic                                 we_i,
   input  logic [$clog2(ROWS)+$clog2(COLS)-1:0] addr_i,
   input  logic [WORD_W-1:0]                    wdata_i,
   output logic                                 ack_o,
   output logic [WORD_W-1:0]                    rdata_o,
   output logic                                 ras_o,
   output logic                                 cas_o,
   output logic                                 pre_o,
   output logic [((ROWS > COLS) ? $clog2(ROWS) : $clog2(COLS))-1:0] bus_addr_o
);
   localparam int MUX_W = (ROWS > COLS) ? $clog2(ROWS) : $clog2(COLS);

   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
      $error("dram_page_ctrl: ROWS must be a power of two >= 2");
   end
   if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
      $error("dram_page_ctrl: COLS must be a power of two >= 2");
   end
   if (REFRESH_CYCLES < 2 * ROWS + 4) begin : g_bad_refresh
      $error("dram_page_ctrl: REFRESH_CYCLES shorter than one refresh burst");
   end

   logic ref_due, ref_start, cwe;

   dpm_refresh #(
      .INTERVAL (REFRESH_CYCLES)
   ) i_refresh (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (ref_start),
      .due_o   (ref_due)
   );

   dpm_seq #(
      .ROWS  (ROWS),
      .COLS  (COLS),
      .T_RCD (T_RCD),
      .T_CL  (T_CL),
      .MUX_W (MUX_W)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .we_i        (we_i),
      .addr_i      (addr_i),
      .ref_due_i   (ref_due),
      .ref_start_o (ref_start),
      .ras_o       (ras_o),
      .cas_o       (cas_o),
      .pre_o       (pre_o),
      .cwe_o       (cwe),
      .mux_o       (bus_addr_o),
      .ack_o       (ack_o)
   );

   dpm_core #(
      .ROWS   (ROWS),
      .COLS   (COLS),
      .WORD_W (WORD_W),
      .MUX_W  (MUX_W)
   ) i_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .ras_i  (ras_o),
      .cas_i  (cas_o),
      .pre_i  (pre_o),
      .we_i   (cwe),
      .addr_i (bus_addr_o),
      .din_i  (wdata_i),
      .dout_o (rdata_o)
   );

   AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(req_i));                                // R1

endmodule

// File: tb/test_dram_page_ctrl.sv
module test_dram_page_ctrl;
   localparam int ROWS = 4, COLS = 4, WORD_W = 8;
   localparam int T_RCD = 2, T_CL = 2, REF = 640;
   localparam int COL_W = 2, NW = ROWS * COLS;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, we = 1'b0;
   logic [3:0] addr = '0;
   logic [WORD_W-1:0] wdata = '0;
   logic ack, ras, cas, pre;
   logic [WORD_W-1:0] rdata;
   logic [1:0] baddr;

   dram_page_ctrl #(
      .ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W),
      .T_RCD(T_RCD), .T_CL(T_CL), .REFRESH_CYCLES(REF)
   ) i_dram_page_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .ras_o(ras),
      .cas_o(cas), .pre_o(pre), .bus_addr_o(baddr)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor state
   bit   in_win = 0, idle_phase = 0, ack_seen = 0;
   int   win_ras = 0, win_cas = 0, cas_cyc = 0, cas_adr = 0, ack_cyc = 0, ack_dat = 0;
   int   spurious_ack = 0, ref_ptr = 0, last_burst = -1, bursts = 0;
   bit   ras_hist [16];
   int   ras_hadr [16];

   always @(posedge clk) begin
      #2;
      cyc++;
      ras_hist[cyc % 16] = ras;
      ras_hadr[cyc % 16] = int'(baddr);
      if (ras) begin
         if (in_win) win_ras++;
         else begin
            mvalid = 0;
            if (idle_phase) begin
               check(int'(baddr) == ref_ptr, "R7 refresh row order", int'(baddr), ref_ptr);
               if (baddr == 0) begin
                  if (last_burst >= 0)
                     check(cyc - last_burst == REF, "R7 refresh spacing", cyc - last_burst, REF);
                  last_burst = cyc;
                  bursts++;
               end
               ref_ptr = (ref_ptr + 1) % ROWS;
            end
         end
      end
      if (cas && in_win) begin
         win_cas++;
         cas_cyc = cyc;
         cas_adr = int'(baddr);
      end
      if (ack) begin
         if (in_win) begin
            ack_seen = 1;
            ack_cyc  = cyc;
            ack_dat  = int'(rdata);
         end else spurious_ack++;
      end
   end

   // reference model
   int mem [NW];
   bit mvalid = 0;
   int mopen = 0;

   task automatic access(input bit w, input int a, input int d, input bit expect_ras_tag = 0);
      int row, col, k;
      bit need, acc_ras, refr;
      row = a >> COL_W;
      col = a % COLS;
      @(negedge clk);
      addr = 4'(a); we = w; wdata = WORD_W'(d); req = 1'b1;
      win_ras = 0; win_cas = 0; ack_seen = 0; in_win = 1;
      need = !mvalid || (row != mopen);
      k = 0;
      while (!ack_seen && k < 2000) begin
         @(negedge clk);
         k++;
      end
      req = 1'b0;
      in_win = 0;
      check(ack_seen, "R1 acknowledge arrives", int'(ack_seen), 1);
      acc_ras = ras_hist[(cas_cyc - T_RCD) % 16] && (ras_hadr[(cas_cyc - T_RCD) % 16] == row);
      refr = (win_ras - int'(acc_ras)) > 0;
      check(win_cas == 1, "R3 one column strobe", win_cas, 1);
      check(cas_adr == col, "R2 column on bus", cas_adr, col);
      if (need || refr)
         check(acc_ras, "R5 row strobe T_RCD before column", int'(acc_ras), 1);
      else
         check(win_ras == 0, "R3 open row reused", win_ras, 0);
      if (expect_ras_tag)
         check(acc_ras, "R8 row strobe after refresh", int'(acc_ras), 1);
      check(ack_cyc - cas_cyc == T_CL, "R6 column to acknowledge", ack_cyc - cas_cyc, T_CL);
      if (!w) check(ack_dat == mem[a], "R4 read data", ack_dat, mem[a]);
      else    mem[a] = d & 255;
      mopen = row;
      mvalid = 1;
      @(posedge clk);
      #2;
      check(!ack, "R1 acknowledge one cycle", int'(ack), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) mem[i] = 0;
      repeat (3) @(negedge clk);
      check(!ack && !ras && !cas && !pre, "R9 strobes low in reset",
            int'({ack, ras, cas, pre}), 0);
      check(rdata == 0, "R9 read data zero in reset", int'(rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: untouched supercell reads zero
      access(0, 5, 0);
      // row-major writes, then reads
      for (int a = 0; a < NW; a++) access(1, a, a * 29 + 7);
      for (int a = 0; a < NW; a++) access(0, a, 0);
      // column-major reads: row changes every access
      for (int c = 0; c < COLS; c++)
         for (int r = 0; r < ROWS; r++) access(0, r * COLS + c, 0);
      // stride writes, reverse reads
      for (int i = 0; i < NW; i++) access(1, (i * 5) % NW, ((i * 5) % NW) * 13 + 90 + i);
      for (int a = NW - 1; a >= 0; a--) access(0, a, 0);
      // idle: refresh cadence and row order
      access(0, 4, 0);
      idle_phase = 1; ref_ptr = 0; last_burst = -1; bursts = 0;
      repeat (2 * REF + 40) @(negedge clk);
      idle_phase = 0;
      check(bursts >= 2, "R7 refresh bursts while idle", bursts, 2);
      check(ref_ptr == 0, "R7 whole bursts", ref_ptr, 0);
      // R8: same row as before refresh must be re-activated
      access(0, 6, 0, 1);
      for (int a = 0; a < NW; a++) access(0, a, 0);
      check(spurious_ack == 0, "R1 no acknowledge without request", spurious_ack, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule